// File: doc/BRIEF.md
# Address Watchpoint Trigger Unit

This unit watches the instruction fetch address of a processor and raises a one-cycle trigger line for each of its watchpoints that the address hits. There are eight watchpoint slots. Each slot has its own match address and its own enable bit. Whenever at least one trigger fires, the unit also freezes a copy of the processor's register file, so that the machine state at the moment of the hit can be read out later.

The match addresses are not only written by the host. After reset the unit waits for the system to report that the first memory initialization is complete. It then reads eight consecutive words from a reserved memory window through a request/acknowledge handshake and puts word i into slot i. Matching stays suppressed until that load has finished, and the load runs only once per reset. A plain register-write port lets the host overwrite any slot address and set the enable mask at any time.

Top module: `wpt_trigger_unit`

## Requirements
- R1: After reset, `trigger` is 0, `loadDone` is 0, `ldReq` is 0 and `snapRegs` is all zeros.
- R2: `ldReq` stays low until `memInitDone` has been seen high. The unit then requests the addresses LOAD_BASE+0 through LOAD_BASE+7 in ascending order. Each request holds its address until the cycle in which `ldAck` is high, and the `ldData` taken with the request for LOAD_BASE+i becomes the match address of watchpoint i.
- R3: `loadDone` rises in the cycle after the eighth accepted acknowledge and then stays high. Once it is set, further changes of `memInitDone` raise no new request.
- R4: No trigger fires while `loadDone` is low, even when the slot addresses and enables would otherwise match.
- R5: `trigger[i]` is high in the cycle after a cycle in which `fetchValid` is high, `fetchAddr` equals the address of watchpoint i and enable bit i is set. It is low in every other cycle, so each matching fetch gives a pulse one cycle long.
- R6: A write with `cfgAddr` = 8 loads `cfgData[7:0]` into the enable mask, bit i belonging to watchpoint i. A watchpoint whose bit is clear never triggers.
- R7: A write with `cfgAddr` = i, for i from 0 to 7, sets the match address of watchpoint i to `cfgData`. Writes with `cfgAddr` from 9 to 15 change neither any address nor the mask.
- R8: When several enabled watchpoints match the same fetch, each raises its own trigger bit in the same cycle and a single snapshot is taken.
- R9: In every cycle with any trigger bit high, `snapRegs` holds the `cpuRegs` value of the matching fetch cycle, with register k in bits [16k+15:16k]. In cycles without a trigger, `snapRegs` keeps its value.
- R10: A cycle with `fetchValid` low causes no trigger, whatever `fetchAddr` is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| memInitDone | input | 1 | High once the first memory initialization has finished |
| ldReq | output | 1 | Read request to the reserved memory window |
| ldAddr | output | 16 | Word address of the current read request |
| ldAck | input | 1 | Read acknowledge; `ldData` is valid with it |
| ldData | input | 16 | Read data word |
| loadDone | output | 1 | High after all eight slot addresses have been loaded |
| cfgWrEn | input | 1 | Register write strobe |
| cfgAddr | input | 4 | Register select: 0-7 slot address, 8 enable mask |
| cfgData | input | 16 | Register write data |
| fetchValid | input | 1 | Fetch address qualifier |
| fetchAddr | input | 16 | Observed instruction fetch address |
| cpuRegs | input | 128 | Processor registers, eight 16-bit lanes |
| trigger | output | 8 | Per-watchpoint trigger pulses |
| snapRegs | output | 128 | Register snapshot from the last trigger |

## Verification
The main sweep tries all 256 enable masks, and under each mask it fetches every loaded slot address once and one address that matches no slot. This sets the one-hot trigger pattern against the mask and shows which bits are wired to which slots. Fetches made before the load completes, or with the qualifier low, show that matching is gated by those two conditions rather than by the address alone. Several slots set to one shared address show that the bits combine into one multi-bit trigger with one snapshot. Varying the acknowledge delay and toggling the initialization flag again after the load show that the load order and address are held, and that the load runs only once.

// File: rtl/wpt_pkg.sv
package wpt_pkg;

  typedef enum logic [1:0] {
    LD_WAIT  = 2'd0,
    LD_FETCH = 2'd1,
    LD_DONE  = 2'd2
  } load_state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic slotWr;   // write ldData into the slot chosen by slotIdx
    logic armed;    // load finished, comparisons allowed
  } ctrl_strobe_t;

endpackage

// File: rtl/wpt_load_ctrl.sv
module wpt_load_ctrl
  import wpt_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int NUM_WP    = 8,
  parameter logic [ADDR_W-1:0] LOAD_BASE = 16'hFF00,
  localparam int IDX_W    = $clog2(NUM_WP)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              memInitDone,
  input  logic              ldAck,
  output logic              ldReq,
  output logic [ADDR_W-1:0] ldAddr,
  output logic [IDX_W-1:0]  slotIdx,
  output ctrl_strobe_t      strobe
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_WP - 1);

  load_state_e      state;
  logic [IDX_W-1:0] idx;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= LD_WAIT;
      idx   <= '0;
    end else begin
      case (state)
        LD_WAIT: begin
          if (memInitDone) state <= LD_FETCH;
        end
        LD_FETCH: begin
          if (ldAck) begin
            if (idx == LAST_IDX) state <= LD_DONE;
            else                 idx   <= idx + 1'b1;
          end
        end
        LD_DONE:  state <= LD_DONE;
        default:  state <= LD_WAIT;
      endcase
    end
  end

  always_comb begin
    ldReq         = (state == LD_FETCH);
    ldAddr        = LOAD_BASE + ADDR_W'(idx);
    slotIdx       = idx;
    strobe.slotWr = ldReq & ldAck;
    strobe.armed  = (state == LD_DONE);
  end

endmodule

// File: rtl/wpt_datapath.sv
module wpt_datapath
  import wpt_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 16,
  parameter int NUM_WP   = 8,
  parameter int NUM_REGS = 8,
  localparam int IDX_W   = $clog2(NUM_WP),
  localparam int CFG_W   = IDX_W + 1,
  localparam int SNAP_W  = NUM_REGS * DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_strobe_t      strobe,
  input  logic [IDX_W-1:0]  slotIdx,
  input  logic [ADDR_W-1:0] ldData,
  input  logic              cfgWrEn,
  input  logic [CFG_W-1:0]  cfgAddr,
  input  logic [ADDR_W-1:0] cfgData,
  input  logic              fetchValid,
  input  logic [ADDR_W-1:0] fetchAddr,
  input  logic [SNAP_W-1:0] cpuRegs,
  output logic [NUM_WP-1:0] trigger,
  output logic [SNAP_W-1:0] snapRegs
);

  localparam logic [CFG_W-1:0] EN_SEL = CFG_W'(NUM_WP);

  logic [ADDR_W-1:0] wpAddr [NUM_WP];
  logic [NUM_WP-1:0] enMask;
  logic [NUM_WP-1:0] hit;
  logic              anyHit;

  for (genvar g = 0; g < NUM_WP; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rstN) begin
        wpAddr[g] <= '0;
      end else if (strobe.slotWr && slotIdx == IDX_W'(g)) begin
        wpAddr[g] <= ldData;
      end else if (cfgWrEn && cfgAddr == CFG_W'(g)) begin
        wpAddr[g] <= cfgData;
      end
    end

    assign hit[g] = strobe.armed & fetchValid & enMask[g] &
                    (fetchAddr == wpAddr[g]);
  end

  always_ff @(posedge clk) begin
    if (!rstN)                               enMask <= '0;
    else if (cfgWrEn && cfgAddr == EN_SEL)   enMask <= cfgData[NUM_WP-1:0];
  end

  assign anyHit = |hit;

  always_ff @(posedge clk) begin
    if (!rstN) trigger <= '0;
    else       trigger <= hit;
  end

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rstN)       snapRegs[k*DATA_W +: DATA_W] <= '0;
      else if (anyHit) snapRegs[k*DATA_W +: DATA_W] <= cpuRegs[k*DATA_W +: DATA_W];
    end
  end

endmodule

// File: rtl/wpt_trigger_unit.sv
module wpt_trigger_unit
  import wpt_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 16,
  parameter int NUM_WP   = 8,
  parameter int NUM_REGS = 8,
  parameter logic [ADDR_W-1:0] LOAD_BASE = 16'hFF00,
  localparam int IDX_W   = $clog2(NUM_WP),
  localparam int CFG_W   = IDX_W + 1,
  localparam int SNAP_W  = NUM_REGS * DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              memInitDone,
  output logic              ldReq,
  output logic [ADDR_W-1:0] ldAddr,
  input  logic              ldAck,
  input  logic [ADDR_W-1:0] ldData,
  output logic              loadDone,
  input  logic              cfgWrEn,
  input  logic [CFG_W-1:0]  cfgAddr,
  input  logic [ADDR_W-1:0] cfgData,
  input  logic              fetchValid,
  input  logic [ADDR_W-1:0] fetchAddr,
  input  logic [SNAP_W-1:0] cpuRegs,
  output logic [NUM_WP-1:0] trigger,
  output logic [SNAP_W-1:0] snapRegs
);

  ctrl_strobe_t     strobe;
  logic [IDX_W-1:0] slotIdx;

  wpt_load_ctrl #(
    .ADDR_W(ADDR_W), .NUM_WP(NUM_WP), .LOAD_BASE(LOAD_BASE)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .memInitDone(memInitDone), .ldAck(ldAck),
    .ldReq(ldReq), .ldAddr(ldAddr), .slotIdx(slotIdx), .strobe(strobe)
  );

  wpt_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_WP(NUM_WP), .NUM_REGS(NUM_REGS)
  ) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .slotIdx(slotIdx),
    .ldData(ldData), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .fetchValid(fetchValid), .fetchAddr(fetchAddr), .cpuRegs(cpuRegs),
    .trigger(trigger), .snapRegs(snapRegs)
  );

  assign loadDone = strobe.armed;

endmodule

// File: rtl/wpt_trigger_chk.sv
module wpt_trigger_chk #(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 16,
  parameter int NUM_WP   = 8,
  parameter int NUM_REGS = 8,
  parameter logic [ADDR_W-1:0] LOAD_BASE = 16'hFF00,
  localparam int SNAP_W  = NUM_REGS * DATA_W
) (
  input logic              clk,
  input logic              rstN,
  input logic              ldReq,
  input logic              ldAck,
  input logic [ADDR_W-1:0] ldAddr,
  input logic              loadDone,
  input logic              fetchValid,
  input logic [SNAP_W-1:0] cpuRegs,
  input logic [NUM_WP-1:0] trigger,
  input logic [SNAP_W-1:0] snapRegs
);

  // R2
  ld_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ldReq && !ldAck |=> ldReq && $stable(ldAddr));

  // R2
  ld_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    ldReq |-> (ADDR_W'(ldAddr - LOAD_BASE) < ADDR_W'(NUM_WP)));

  // R2
  ld_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    ldReq && ldAck |=> loadDone || (ldReq && ldAddr == ADDR_W'($past(ldAddr) + 1'b1)));

  // R3
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    loadDone |=> loadDone);

  // R3
  done_noreq_chk: assert property (@(posedge clk) disable iff (!rstN)
    loadDone |-> !ldReq);

  // R4
  trig_armed_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|trigger) |-> $past(loadDone));

  // R10
  trig_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|trigger) |-> $past(fetchValid));

  // R9
  snap_take_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|trigger) |-> snapRegs == $past(cpuRegs));

  // R9
  snap_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(|trigger) |-> $stable(snapRegs));

endmodule

bind wpt_trigger_unit wpt_trigger_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_WP(NUM_WP),
  .NUM_REGS(NUM_REGS), .LOAD_BASE(LOAD_BASE)
) i_chk (
  .clk(clk), .rstN(rstN), .ldReq(ldReq), .ldAck(ldAck), .ldAddr(ldAddr),
  .loadDone(loadDone), .fetchValid(fetchValid), .cpuRegs(cpuRegs),
  .trigger(trigger), .snapRegs(snapRegs)
);

// File: tb/test_wpt_trigger_unit.sv
`timescale 1ns/1ps
module test_wpt_trigger_unit;

  localparam logic [15:0] BASE = 16'hFF00;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         memInitDone = 1'b0;
  logic         ldReq;
  logic [15:0]  ldAddr;
  logic         ldAck = 1'b0;
  logic [15:0]  ldData = '0;
  logic         loadDone;
  logic         cfgWrEn = 1'b0;
  logic [3:0]   cfgAddr = '0;
  logic [15:0]  cfgData = '0;
  logic         fetchValid = 1'b0;
  logic [15:0]  fetchAddr = '0;
  logic [127:0] cpuRegs = '0;
  logic [7:0]   trigger;
  logic [127:0] snapRegs;

  wpt_trigger_unit i_wpt_trigger_unit (
    .clk(clk), .rstN(rstN), .memInitDone(memInitDone),
    .ldReq(ldReq), .ldAddr(ldAddr), .ldAck(ldAck), .ldData(ldData),
    .loadDone(loadDone), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgData(cfgData), .fetchValid(fetchValid), .fetchAddr(fetchAddr),
    .cpuRegs(cpuRegs), .trigger(trigger), .snapRegs(snapRegs)
  );

  always #10 clk = ~clk;

  int          nChecks = 0;
  int          nFails  = 0;
  bit          finished = 1'b0;
  logic [15:0] expWp [8];
  logic [7:0]  expEn = '0;
  bit          loaded = 1'b0;
  logic [127:0] expSnap = '0;
  logic [15:0] seed = 16'h0001;

  task automatic check(input bit ok, input string tag, input logic [127:0] act,
                       input logic [127:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] memWord(input logic [15:0] a);
    return a ^ 16'h3C5A;
  endfunction

  function automatic logic [127:0] pattern(input logic [15:0] s);
    logic [127:0] r;
    for (int k = 0; k < 8; k++) r[k*16 +: 16] = {s[7:0], 8'(k)} ^ 16'h9E37;
    return r;
  endfunction

  function automatic logic [7:0] expTrig(input logic v, input logic [15:0] a);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = v && loaded && expEn[i] && (a == expWp[i]);
    return r;
  endfunction

  task automatic cfgWrite(input logic [3:0] sel, input logic [15:0] d);
    cfgWrEn = 1'b1; cfgAddr = sel; cfgData = d;
    @(negedge clk);
    cfgWrEn = 1'b0;
    if (sel < 4'd8) expWp[sel[2:0]] = d;
    else if (sel == 4'd8) expEn = d[7:0];
  endtask

  // drive one fetch cycle, check trigger and snapshot one cycle later
  task automatic fetch(input logic [15:0] a, input logic v, input string tag);
    logic [7:0]   et;
    logic [127:0] pat;
    seed++;
    pat = pattern(seed);
    fetchValid = v; fetchAddr = a; cpuRegs = pat;
    et = expTrig(v, a);
    @(negedge clk);
    fetchValid = 1'b0;
    if (et != 0) expSnap = pat;
    check(trigger == et, {tag, " trigger"}, 128'(trigger), 128'(et));
    check(snapRegs == expSnap, {tag, " snapshot"}, snapRegs, expSnap);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) expWp[i] = '0;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(trigger == 0, "R1 trigger", 128'(trigger), 0);
    check(loadDone == 0, "R1 loadDone", 128'(loadDone), 0);
    check(ldReq == 0, "R1 ldReq", 128'(ldReq), 0);
    check(snapRegs == 0, "R1 snapRegs", snapRegs, 0);

    // R4: matching config before load gives no trigger
    cfgWrite(4'd0, 16'h1234);
    cfgWrite(4'd8, 16'h00FF);
    fetch(16'h1234, 1'b1, "R4 pre-load match");

    // R2: no request before memInitDone
    repeat (10) @(negedge clk);
    check(ldReq == 0, "R2 idle before init", 128'(ldReq), 0);

    memInitDone = 1'b1;
    for (int n = 0; n < 8; n++) begin
      int guard = 0;
      while (!ldReq && guard < 20) begin @(negedge clk); guard++; end
      check(ldReq == 1, "R2 request raised", 128'(ldReq), 1);
      check(ldAddr == BASE + 16'(n), "R2 request address", 128'(ldAddr),
            128'(BASE + 16'(n)));
      for (int w = 0; w < n % 3; w++) begin
        @(negedge clk);
        check(ldReq && ldAddr == BASE + 16'(n), "R2 request held",
              128'(ldAddr), 128'(BASE + 16'(n)));
      end
      if (n == 7) check(loadDone == 0, "R3 not done before last ack", 128'(loadDone), 0);
      ldAck = 1'b1; ldData = memWord(ldAddr);
      expWp[n] = memWord(BASE + 16'(n));
      @(negedge clk);
      ldAck = 1'b0;
    end
    check(loadDone == 1, "R3 done after eighth ack", 128'(loadDone), 1);
    check(ldReq == 0, "R3 request dropped", 128'(ldReq), 0);
    loaded = 1'b1;

    // R3: re-toggling init does not reload
    memInitDone = 1'b0;
    repeat (3) @(negedge clk);
    memInitDone = 1'b1;
    repeat (3) begin
      @(negedge clk);
      check(ldReq == 0 && loadDone == 1, "R3 no reload", 128'({ldReq, loadDone}), 128'(2'b01));
    end

    // R5 R6 R2: full mask sweep over loaded addresses
    for (int m = 0; m < 256; m++) begin
      cfgWrite(4'd8, 16'(m));
      for (int i = 0; i < 8; i++) fetch(expWp[i], 1'b1, "R5 R6 sweep");
      fetch(16'h0001, 1'b1, "R5 no-match");
    end

    // R5: back-to-back matches pulse each cycle, then drop
    cfgWrite(4'd8, 16'h00FF);
    fetch(expWp[5], 1'b1, "R5 repeat first");
    fetch(expWp[5], 1'b1, "R5 repeat second");
    fetch(16'h0000, 1'b0, "R5 pulse end");

    // R10: invalid fetch at a watched address
    for (int i = 0; i < 8; i++) fetch(expWp[i], 1'b0, "R10 invalid fetch");

    // R7: host overwrite of a slot, and ignored codes
    cfgWrite(4'd3, 16'hBEEF);
    fetch(16'hBEEF, 1'b1, "R7 new slot address");
    fetch(memWord(BASE + 16'd3), 1'b1, "R7 old slot address");
    for (int c = 9; c < 16; c++) cfgWrite(4'(c), 16'h0000);
    for (int i = 0; i < 8; i++) fetch(expWp[i], 1'b1, "R7 ignored codes");
    fetch(16'h0000, 1'b1, "R7 ignored codes zero addr");

    // R8: shared address on several slots
    cfgWrite(4'd1, 16'h4444);
    cfgWrite(4'd4, 16'h4444);
    cfgWrite(4'd7, 16'h4444);
    fetch(16'h4444, 1'b1, "R8 triple match");
    cfgWrite(4'd8, 16'h0012);
    fetch(16'h4444, 1'b1, "R8 masked match");
    fetch(16'h4444, 1'b0, "R9 snapshot held");

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule